// File: doc/BRIEF.md
# Bridge Reset Sequencer

This block turns the reset causes seen by a bus bridge into three nested internal reset levels and one reset pin for the secondary bus. It watches a supply-good flag and a reference-clock activity flag for power-on, plus an asynchronous global reset pin, a link reset pin, an in-band hot reset level from the link layer, and a software bit that resets the secondary bus.

The deepest level (`full_rst_n`) clears everything, sticky state included. The middle level (`nonsticky_rst_n`) spares sticky state. The shallowest level (`volatile_rst_n`) spares both sticky state and the bits loaded from the EEPROM. Each level is also asserted whenever a deeper level is asserted.

When the middle level is released, the block raises a one-cycle strobe that latches the static straps. In the same cycle it starts an EEPROM download if an EEPROM is fitted. After a fixed wait it enables link training.

Top module: `bridge_rst_seq`

## Requirements
- R1: While `supply_ok` is low, all reset outputs are low (asserted) and `train_en` is low. A fall of `supply_ok` takes effect at once, without waiting for a clock edge.
- R2: After `supply_ok` rises and has passed through a two-stage synchronizer, the block waits for `refclk_active`. `full_rst_n` rises POR_WAIT_US × (CLK_KHZ/1000) clock cycles after the first clock edge that samples `refclk_active` high, provided `gbl_rst_n` is also released.
- R3: If `refclk_active` falls before the power-on wait has finished, the wait starts over from zero at the next sampled high.
- R4: A low on `gbl_rst_n` drives all four reset outputs low at once. After `gbl_rst_n` rises, the release comes on the second clock edge.
- R5: A low on `lnk_rst_n` drives `nonsticky_rst_n`, `volatile_rst_n` and `sec_bus_rst_n` low at once and leaves `full_rst_n` unchanged. Its release also takes two clock edges.
- R6: `hot_rst` is sampled on the clock. In the cycle after it is sampled high, `volatile_rst_n` and `sec_bus_rst_n` are low, while `full_rst_n`, `nonsticky_rst_n` and `train_en` keep their values.
- R7: `sec_bus_rst_n` is low in the same cycle that `sec_rst_bit` is 1, and follows the shallowest level when the bit is 0. The bit has no effect on any other output.
- R8: `strap_latch` is high for exactly one cycle: the cycle after `nonsticky_rst_n` goes from low to high. `eeprom_start` equals `strap_latch` when `eeprom_present` is 1 and stays 0 otherwise.
- R9: `train_en` is low while `nonsticky_rst_n` is low. It rises TRAIN_WAIT_US × (CLK_KHZ/1000) cycles after the cycle in which `strap_latch` is high, then stays high until the middle level is asserted again.
- R10: The levels are nested: a low on `full_rst_n` implies a low on `nonsticky_rst_n`, which implies a low on `volatile_rst_n`, which implies a low on `sec_bus_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| supply_ok | input | 1 | Supply comparator reports at least 90 % of nominal |
| refclk_active | input | 1 | Reference clock detected as toggling |
| gbl_rst_n | input | 1 | Global reset pin, asynchronous, active low |
| lnk_rst_n | input | 1 | Link reset pin, active low |
| hot_rst | input | 1 | In-band hot reset / link-down level, synchronous |
| sec_rst_bit | input | 1 | Software bridge-control bit that resets the secondary bus |
| eeprom_present | input | 1 | An external serial EEPROM was detected |
| full_rst_n | output | 1 | Deepest reset level, includes sticky state |
| nonsticky_rst_n | output | 1 | Reset that spares sticky state |
| volatile_rst_n | output | 1 | Reset that spares sticky and EEPROM-loaded state |
| sec_bus_rst_n | output | 1 | Secondary bus reset pin |
| strap_latch | output | 1 | One-cycle strobe to latch static straps |
| eeprom_start | output | 1 | One-cycle EEPROM download start |
| train_en | output | 1 | Link training enable |

## Verification
The hardest case to reach is a reference clock that stops in the middle of the power-on wait. A second attempt must then count the full wait again and not resume from the partial count. To reach it, the bench holds `refclk_active` high for a fraction of the window, drops it for a few cycles, and raises it again. It then times the release edge cycle by cycle against a behavioural model. It also layers the software bit, the hot reset, the link reset and a mid-cycle global reset on top of a running link, so that the nesting of the levels and the re-arming of the training timer are seen under overlapping sources.

// File: rtl/bridge_rst_pkg.sv
package bridge_rst_pkg;

  typedef enum logic [1:0] {
    PWR_WAIT_CLK = 2'd0,
    PWR_COUNT    = 2'd1,
    PWR_DONE     = 2'd2
  } pwr_state_e;

  // Width needed to hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/brs_sync.sv
// Reset synchronizer: asserts asynchronously, releases after STAGES clock edges.
module brs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rel_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rel_o = sh_q[STAGES-1];

endmodule

// File: rtl/brs_por_ctrl.sv
// Power-on release: wait for reference clock activity, then count WAIT_CYC cycles.
module brs_por_ctrl
  import bridge_rst_pkg::*;
#(
  parameter int WAIT_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refclk_ok,
  output logic done_o
);

  localparam int CW = cnt_width(WAIT_CYC);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

  pwr_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      PWR_WAIT_CLK: begin
        if (refclk_ok) begin
          state_d = PWR_COUNT;
          cnt_d   = '0;
        end
      end
      PWR_COUNT: begin
        if (!refclk_ok) begin
          state_d = PWR_WAIT_CLK;
          cnt_d   = '0;
        end else if (cnt_q == LAST) begin
          state_d = PWR_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PWR_DONE: state_d = PWR_DONE;
      default: begin
        state_d = PWR_WAIT_CLK;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWR_WAIT_CLK;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign done_o = (state_q == PWR_DONE);

  AST_POR_NEEDS_REFCLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(refclk_ok)); // R2

  AST_POR_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o); // R2

  AST_POR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (!refclk_ok && !done_o) |=> !done_o); // R3

endmodule

// File: rtl/brs_train_timer.sv
// Counts LIMIT cycles of an uninterrupted run level, then raises en_o.
module brs_train_timer
  import bridge_rst_pkg::*;
#(
  parameter int LIMIT = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic en_o
);

  localparam int CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          en_q, en_d;
  logic          upd;

  assign upd = !run_i || !en_q;

  always_comb begin
    cnt_d = cnt_q;
    en_d  = en_q;
    if (!run_i) begin
      cnt_d = '0;
      en_d  = 1'b0;
    end else if (cnt_q == LAST) begin
      en_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
    end
  end

  assign en_o = en_q;

  AST_TRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && run_i) |=> en_o); // R9

  AST_TRAIN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !en_o); // R9

endmodule

// File: rtl/bridge_rst_seq.sv
module bridge_rst_seq
  import bridge_rst_pkg::*;
#(
  parameter int CLK_KHZ       = 250000,
  parameter int POR_WAIT_US   = 10,
  parameter int TRAIN_WAIT_US = 80000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic supply_ok,
  input  logic refclk_active,
  input  logic gbl_rst_n,
  input  logic lnk_rst_n,
  input  logic hot_rst,
  input  logic sec_rst_bit,
  input  logic eeprom_present,
  output logic full_rst_n,
  output logic nonsticky_rst_n,
  output logic volatile_rst_n,
  output logic sec_bus_rst_n,
  output logic strap_latch,
  output logic eeprom_start,
  output logic train_en
);

  localparam int CYC_PER_US = CLK_KHZ / 1000;
  localparam int POR_CYC    = CYC_PER_US * POR_WAIT_US;
  localparam int TRAIN_CYC  = CYC_PER_US * TRAIN_WAIT_US;

  logic pwr_rel, gbl_rel, lnk_rel, por_done;
  logic hot_q, hot_d;
  logic ns_prev_q, ns_prev_d;

  brs_sync #(.STAGES(SYNC_STAGES)) u_sync_pwr (
    .clk(clk), .arst_n(supply_ok), .rel_o(pwr_rel));
  brs_sync #(.STAGES(SYNC_STAGES)) u_sync_gbl (
    .clk(clk), .arst_n(gbl_rst_n), .rel_o(gbl_rel));
  brs_sync #(.STAGES(SYNC_STAGES)) u_sync_lnk (
    .clk(clk), .arst_n(lnk_rst_n), .rel_o(lnk_rel));

  brs_por_ctrl #(.WAIT_CYC(POR_CYC)) u_por (
    .clk(clk), .rst_n(pwr_rel), .refclk_ok(refclk_active), .done_o(por_done));

  // Tiered reset levels: each shallower level includes the deeper ones
  assign full_rst_n      = por_done && gbl_rel;
  assign nonsticky_rst_n = full_rst_n && lnk_rel;
  assign volatile_rst_n  = nonsticky_rst_n && !hot_q;
  assign sec_bus_rst_n   = volatile_rst_n && !sec_rst_bit;

  always_comb begin
    hot_d     = hot_rst;
    ns_prev_d = nonsticky_rst_n;
  end

  always_ff @(posedge clk or negedge pwr_rel) begin
    if (!pwr_rel) begin
      hot_q     <= 1'b0;
      ns_prev_q <= 1'b0;
    end else begin
      hot_q     <= hot_d;
      ns_prev_q <= ns_prev_d;
    end
  end

  assign strap_latch  = nonsticky_rst_n && !ns_prev_q;
  assign eeprom_start = strap_latch && eeprom_present;

  brs_train_timer #(.LIMIT(TRAIN_CYC)) u_train (
    .clk(clk), .rst_n(pwr_rel), .run_i(nonsticky_rst_n), .en_o(train_en));

  AST_TIER_NEST: assert property (@(posedge clk) disable iff (!supply_ok)
    (!full_rst_n |-> !nonsticky_rst_n) and (!nonsticky_rst_n |-> !volatile_rst_n)
    and (!volatile_rst_n |-> !sec_bus_rst_n)); // R10

  AST_GBL_FULL: assert property (@(posedge clk) disable iff (!supply_ok)
    !gbl_rst_n |-> !full_rst_n); // R4

  AST_LNK_NONSTICKY: assert property (@(posedge clk) disable iff (!supply_ok)
    !lnk_rst_n |-> !nonsticky_rst_n); // R5

  AST_HOT_VOLATILE: assert property (@(posedge clk) disable iff (!supply_ok)
    hot_rst |=> !volatile_rst_n); // R6

  AST_STRAP_ONE: assert property (@(posedge clk) disable iff (!supply_ok)
    strap_latch |=> !strap_latch); // R8

endmodule

// File: tb/sim_bridge_rst_seq.sv
`timescale 1ns/1ps
module sim_bridge_rst_seq;

  localparam int N = 2500;   // 10 us at 250 MHz
  localparam int T = 20000;  // 80 us (scaled training wait) at 250 MHz

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic supply_ok, refclk_active, gbl_rst_n, lnk_rst_n, hot_rst, sec_rst_bit, eeprom_present;
  logic full_rst_n, nonsticky_rst_n, volatile_rst_n, sec_bus_rst_n, strap_latch, eeprom_start, train_en;

  bridge_rst_seq #(.CLK_KHZ(250000), .POR_WAIT_US(10), .TRAIN_WAIT_US(80)) u0 (
    .clk(clk), .supply_ok(supply_ok), .refclk_active(refclk_active),
    .gbl_rst_n(gbl_rst_n), .lnk_rst_n(lnk_rst_n), .hot_rst(hot_rst),
    .sec_rst_bit(sec_rst_bit), .eeprom_present(eeprom_present),
    .full_rst_n(full_rst_n), .nonsticky_rst_n(nonsticky_rst_n),
    .volatile_rst_n(volatile_rst_n), .sec_bus_rst_n(sec_bus_rst_n),
    .strap_latch(strap_latch), .eeprom_start(eeprom_start), .train_en(train_en));

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Behavioural reference state
  int s_c = 0, g_c = 0, l_c = 0;
  int p_stage = 0, p_cnt = 0, t_cnt = 0;
  bit m_hot = 0, m_nsprev = 0, m_train = 0;

  function automatic bit e_full();
    return gbl_rst_n && g_c >= 2 && supply_ok && p_stage == 2;
  endfunction
  function automatic bit e_ns();
    return e_full() && lnk_rst_n && l_c >= 2;
  endfunction

  always @(posedge clk) begin
    bit s_rel, ns;
    s_rel = supply_ok && s_c >= 2;
    ns = e_ns();
    s_c = supply_ok ? ((s_c < 2) ? s_c + 1 : 2) : 0;
    g_c = gbl_rst_n ? ((g_c < 2) ? g_c + 1 : 2) : 0;
    l_c = lnk_rst_n ? ((l_c < 2) ? l_c + 1 : 2) : 0;
    if (!s_rel) begin
      p_stage = 0; p_cnt = 0; m_hot = 0; m_nsprev = 0; t_cnt = 0; m_train = 0;
    end else begin
      if (p_stage == 0) begin
        if (refclk_active) begin p_stage = 1; p_cnt = 0; end
      end else if (p_stage == 1) begin
        if (!refclk_active) begin p_stage = 0; p_cnt = 0; end
        else if (p_cnt == N - 1) p_stage = 2;
        else p_cnt++;
      end
      m_hot = hot_rst;
      m_nsprev = ns;
      if (!ns) begin t_cnt = 0; m_train = 0; end
      else if (!m_train) begin
        if (t_cnt == T - 1) m_train = 1; else t_cnt++;
      end
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle compare against the model
  always @(negedge clk) begin
    bit f, ns, vol, sb, st;
    f   = e_full();
    ns  = e_ns();
    vol = ns && !(m_hot && supply_ok);
    sb  = vol && !sec_rst_bit;
    st  = ns && !(m_nsprev && supply_ok);
    chk(full_rst_n, f, "R1 full_rst_n model");
    chk(nonsticky_rst_n, ns, "R5 nonsticky_rst_n model");
    chk(volatile_rst_n, vol, "R6 volatile_rst_n model");
    chk(sec_bus_rst_n, sb, "R7 sec_bus_rst_n model");
    chk(strap_latch, st, "R8 strap_latch model");
    chk(eeprom_start, st && eeprom_present, "R8 eeprom_start model");
    chk(train_en, m_train && supply_ok, "R9 train_en model");
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    supply_ok = 1; gbl_rst_n = 1; lnk_rst_n = 1; refclk_active = 0;
    hot_rst = 0; sec_rst_bit = 0; eeprom_present = 1;
    #1 supply_ok = 0; gbl_rst_n = 0; lnk_rst_n = 0;
    repeat (5) @(negedge clk);
    chk(full_rst_n, 0, "R1 reset full"); chk(sec_bus_rst_n, 0, "R1 reset sec");
    chk(train_en, 0, "R1 reset train");

    @(posedge clk); #1 supply_ok = 1; gbl_rst_n = 1; lnk_rst_n = 1;
    repeat (20) @(negedge clk);
    chk(full_rst_n, 0, "R2 held without refclk");

    // Partial wait, refclk lost, restart (R3)
    @(posedge clk); #1 refclk_active = 1;
    repeat (100) @(negedge clk);
    chk(full_rst_n, 0, "R3 partial wait");
    @(posedge clk); #1 refclk_active = 0;
    repeat (3) @(negedge clk);
    @(posedge clk); #1 refclk_active = 1;
    @(posedge clk);
    repeat (N) @(negedge clk);
    chk(full_rst_n, 0, "R3 count restarted, not yet released");
    @(negedge clk);
    chk(full_rst_n, 1, "R2 release after wait");
    chk(strap_latch, 1, "R8 strap on release");
    chk(eeprom_start, 1, "R8 eeprom start with eeprom");
    @(negedge clk);
    chk(strap_latch, 0, "R8 strap one cycle");
    repeat (T - 2) @(negedge clk);
    chk(train_en, 0, "R9 train before limit");
    @(negedge clk);
    chk(train_en, 1, "R9 train at limit");

    // Software secondary reset (R7)
    @(posedge clk); #1 sec_rst_bit = 1;
    @(negedge clk);
    chk(sec_bus_rst_n, 0, "R7 sec asserted"); chk(volatile_rst_n, 1, "R7 volatile untouched");
    chk(nonsticky_rst_n, 1, "R7 nonsticky untouched");
    @(posedge clk); #1 sec_rst_bit = 0;
    @(negedge clk);
    chk(sec_bus_rst_n, 1, "R7 sec released");

    // Hot reset (R6)
    @(posedge clk); #1 hot_rst = 1;
    @(negedge clk);
    chk(volatile_rst_n, 1, "R6 not before sample");
    @(negedge clk);
    chk(volatile_rst_n, 0, "R6 volatile asserted"); chk(sec_bus_rst_n, 0, "R10 sec nested");
    chk(nonsticky_rst_n, 1, "R6 nonsticky kept"); chk(full_rst_n, 1, "R6 full kept");
    chk(train_en, 1, "R6 train kept");
    @(posedge clk); #1 hot_rst = 0;
    repeat (2) @(negedge clk);
    chk(volatile_rst_n, 1, "R6 volatile released");

    // Link reset (R5), re-strap without EEPROM (R8)
    @(posedge clk); #1 eeprom_present = 0; lnk_rst_n = 0;
    #1 chk(nonsticky_rst_n, 0, "R5 async assert"); chk(full_rst_n, 1, "R5 full kept");
    repeat (2) @(negedge clk);
    chk(train_en, 0, "R9 train cleared by link reset");
    @(posedge clk); #1 lnk_rst_n = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(nonsticky_rst_n, 1, "R5 release after two edges");
    chk(strap_latch, 1, "R8 strap on link release");
    chk(eeprom_start, 0, "R8 no eeprom start without eeprom");
    repeat (T - 1) @(negedge clk);
    chk(train_en, 0, "R9 retrain before limit");
    @(negedge clk);
    chk(train_en, 1, "R9 retrain at limit");

    // Global reset, asserted between edges (R4)
    @(posedge clk); #1 gbl_rst_n = 0;
    #1 chk(full_rst_n, 0, "R4 async full"); chk(volatile_rst_n, 0, "R4 async volatile");
    chk(sec_bus_rst_n, 0, "R4 async sec");
    repeat (3) @(negedge clk);
    @(posedge clk); #1 gbl_rst_n = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(full_rst_n, 1, "R4 release after two edges");
    chk(strap_latch, 1, "R8 strap on global release");

    // Supply drop (R1)
    @(posedge clk); #1 supply_ok = 0;
    #1 chk(full_rst_n, 0, "R1 async supply drop"); chk(nonsticky_rst_n, 0, "R1 nonsticky on drop");
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule